// File: doc/BRIEF.md
# Multiplexed Byte Channel Engine

This block carries out start commands from a processor by running chains of command words held in memory on behalf of many slow devices. One transfer engine is shared among a parameterised number of subchannels (up to 256). Each subchannel keeps its own context: the location of its next command word, the current memory address and the bytes still to move. After a start, the engine reads the command word through a simple memory port with one cycle of read latency. It then moves bytes one at a time between memory and the device attached to that subchannel.

Devices ask for service on a per-subchannel request line. The engine rotates its attention across all subchannels that have work, so that slow devices share the engine byte by byte. When a subchannel's chain ends, the engine latches a completion for it and raises an interrupt. The number of the completed subchannel is reported until the processor acknowledges it.

Top module: `mpx_channel`

## Requirements
- R1: After reset, irq, mem_req, every dev_gnt bit, start_accept and start_busy are all low.
- R2: A start to an inactive subchannel gives start_accept high for one cycle, one cycle after start_valid. The engine then reads the command word at start_ptr.
- R3: A start to a subchannel that is still active gives start_busy high one cycle after start_valid and leaves start_accept low. The running program is not disturbed.
- R4: A command word is laid out as operation in bits [31:24], memory address in [23:8] and byte count in [7:0]. With operation bit 0 clear (output), the engine delivers exactly count bytes on dev_wdata, read from consecutive ascending addresses starting at the word's address, one byte per dev_gnt pulse.
- R5: With operation bit 0 set (input), each dev_gnt pulse writes the requesting device's byte to memory at consecutive ascending addresses starting at the word's address, for exactly count bytes.
- R6: With operation bit 7 set, the end of a command makes the engine fetch the next command word at the following word address. With bit 7 clear, the program ends.
- R7: A command word with count zero ends at once and moves no byte.
- R8: When a program ends, irq rises and irq_sub names the subchannel. If several completions are pending, the lowest-numbered one is reported first. irq_ack clears the reported completion.
- R9: At most one dev_gnt bit is high in any cycle. Subchannels that request at the same time are served round-robin, one byte per grant.
- R10: A device request on a subchannel with no running program is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Start command strobe |
| start_sub | input | SW | Subchannel named by the start |
| start_ptr | input | AW | Word address of the first command word |
| start_accept | output | 1 | Start taken (one cycle after strobe) |
| start_busy | output | 1 | Start refused, subchannel active |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | CW | Read data, valid the cycle after a read |
| dev_req | input | NSUB | Per-subchannel device service request |
| dev_gnt | output | NSUB | Per-subchannel one-byte grant |
| dev_wdata | output | 8 | Byte to the granted output device |
| dev_rdata | input | 8*NSUB | Bytes offered by each device, subchannel i in bits [8i+7:8i] |
| irq | output | 1 | Completion interrupt |
| irq_sub | output | SW | Subchannel whose completion is reported |
| irq_ack | input | 1 | Clears the reported completion |

## Verification
The bench targets chained programs whose first command has a zero count. A design that transferred a byte before looking at the count, or that dropped the chain bit when the count was zero, would show extra bytes or a missing second command. It starts an already running subchannel and expects the busy response with the original transfer intact. A design that reloaded the pointer would fetch the wrong program. With two devices requesting together it expects strict alternation and lowest-first interrupt reporting, so an arbiter that favoured one index, or an interrupt register that kept only the last completion, would be caught. It also holds a request high on an idle subchannel and expects no grant.

// File: rtl/mpx_pkg.sv
package mpx_pkg;
   typedef enum logic [2:0] {
      ST_ARB,
      ST_CMD,
      ST_CMDW,
      ST_IN,
      ST_ORD,
      ST_OGNT
   } eng_st_t;
endpackage

// File: rtl/mpx_rr_pick.sv
module mpx_rr_pick #(
   parameter int N  = 8,
   localparam int SW = $clog2(N)
) (
   input  logic [N-1:0]  elig,
   input  logic [SW-1:0] last,
   output logic [SW-1:0] pick,
   output logic          pick_vld
);
   logic [SW-1:0] idx;

   always_comb begin
      pick     = '0;
      pick_vld = 1'b0;
      idx      = '0;
      for (int k = 1; k <= N; k++) begin
         idx = last + SW'(k);
         if (!pick_vld && elig[idx]) begin
            pick_vld = 1'b1;
            pick     = idx;
         end
      end
   end
endmodule

// File: rtl/mpx_irq.sv
module mpx_irq #(
   parameter int N  = 8,
   localparam int SW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_vld,
   input  logic [SW-1:0] set_idx,
   input  logic          ack,
   output logic          irq,
   output logic [SW-1:0] irq_sub
);
   logic [N-1:0] pend_q;
   logic [N-1:0] set_oh;
   logic [N-1:0] clr_oh;

   always_comb begin
      irq_sub = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend_q[i]) irq_sub = SW'(i);
      end
   end

   assign irq    = |pend_q;
   assign set_oh = set_vld ? (N'(1) << set_idx) : '0;
   assign clr_oh = (ack && irq) ? (N'(1) << irq_sub) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_oh) | set_oh;
   end

   // R8
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq && !(set_vld && set_idx == irq_sub)) |=> !pend_q[$past(irq_sub)]);
   // R8
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack) |=> irq);
endmodule

// File: rtl/mpx_channel.sv
module mpx_channel
   import mpx_pkg::*;
#(
   parameter int NSUB  = 8,
   parameter int AW    = 16,
   parameter int CNT_W = 8,
   parameter int OP_W  = 8,
   localparam int SW   = $clog2(NSUB),
   localparam int CW   = OP_W + AW + CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_valid,
   input  logic [SW-1:0]     start_sub,
   input  logic [AW-1:0]     start_ptr,
   output logic              start_accept,
   output logic              start_busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [CW-1:0]     mem_rdata,
   input  logic [NSUB-1:0]   dev_req,
   output logic [NSUB-1:0]   dev_gnt,
   output logic [7:0]        dev_wdata,
   input  logic [8*NSUB-1:0] dev_rdata,
   output logic              irq,
   output logic [SW-1:0]     irq_sub,
   input  logic              irq_ack
);
   localparam int OP_LSB  = AW + CNT_W;
   localparam int BIT_IN  = OP_LSB;
   localparam int BIT_CHN = OP_LSB + OP_W - 1;

   initial begin
      assert (NSUB >= 2 && NSUB <= 256 && (NSUB & (NSUB - 1)) == 0)
         else $error("NSUB must be a power of two from 2 to 256");
      assert (OP_W >= 2 && CNT_W >= 1 && AW >= 8)
         else $error("field widths too small");
   end

   eng_st_t       state;
   logic [SW-1:0] cur, lst_q;
   logic [AW-1:0]    ptr_q [NSUB];
   logic [AW-1:0]    adr_q [NSUB];
   logic [CNT_W-1:0] cnt_q [NSUB];
   logic [NSUB-1:0]  act_q, fet_q, dir_q, chn_q;

   logic [NSUB-1:0]  elig;
   logic [SW-1:0]    pick;
   logic             pick_vld;
   logic             st_ok, step, cmd_end, end_chain, done_vld;
   logic [AW-1:0]    w_adr;
   logic [CNT_W-1:0] w_cnt;
   logic             w_dir, w_chn;
   logic             unused_bits;

   assign w_adr = mem_rdata[CNT_W +: AW];
   assign w_cnt = mem_rdata[CNT_W-1:0];
   assign w_dir = mem_rdata[BIT_IN];
   assign w_chn = mem_rdata[BIT_CHN];
   assign unused_bits = ^mem_rdata[BIT_CHN-1:BIT_IN+1];

   assign elig  = act_q & (fet_q | dev_req);
   assign st_ok = start_valid && !act_q[start_sub];

   mpx_rr_pick #(.N(NSUB)) u_pick (
      .elig     (elig),
      .last     (lst_q),
      .pick     (pick),
      .pick_vld (pick_vld)
   );

   always_comb begin
      step      = (state == ST_IN) || (state == ST_OGNT);
      cmd_end   = 1'b0;
      end_chain = 1'b0;
      if (state == ST_CMDW && w_cnt == '0) begin
         cmd_end   = 1'b1;
         end_chain = w_chn;
      end else if (step && cnt_q[cur] == CNT_W'(1)) begin
         cmd_end   = 1'b1;
         end_chain = chn_q[cur];
      end
      done_vld = cmd_end && !end_chain;
   end

   always_comb begin
      mem_req   = (state == ST_CMD) || (state == ST_IN) || (state == ST_ORD);
      mem_we    = (state == ST_IN);
      mem_addr  = (state == ST_CMD) ? ptr_q[cur] : adr_q[cur];
      mem_wdata = dev_rdata[cur*8 +: 8];
      dev_gnt   = step ? (NSUB'(1) << cur) : '0;
      dev_wdata = (state == ST_OGNT) ? mem_rdata[7:0] : 8'h00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_ARB;
         cur          <= '0;
         lst_q        <= '0;
         start_accept <= 1'b0;
         start_busy   <= 1'b0;
         act_q        <= '0;
         fet_q        <= '0;
         dir_q        <= '0;
         chn_q        <= '0;
         for (int i = 0; i < NSUB; i++) begin
            ptr_q[i] <= '0;
            adr_q[i] <= '0;
            cnt_q[i] <= '0;
         end
      end else begin
         start_accept <= st_ok;
         start_busy   <= start_valid && act_q[start_sub];
         case (state)
            ST_ARB: if (pick_vld) begin
               cur   <= pick;
               lst_q <= pick;
               if (fet_q[pick])      state <= ST_CMD;
               else if (dir_q[pick]) state <= ST_IN;
               else                  state <= ST_ORD;
            end
            ST_CMD:  state <= ST_CMDW;
            ST_CMDW: begin
               adr_q[cur] <= w_adr;
               cnt_q[cur] <= w_cnt;
               dir_q[cur] <= w_dir;
               chn_q[cur] <= w_chn;
               fet_q[cur] <= 1'b0;
               state      <= ST_ARB;
            end
            ST_ORD:  state <= ST_OGNT;
            ST_IN, ST_OGNT: begin
               adr_q[cur] <= adr_q[cur] + AW'(1);
               cnt_q[cur] <= cnt_q[cur] - CNT_W'(1);
               state      <= ST_ARB;
            end
            default: state <= ST_ARB;
         endcase
         if (cmd_end) begin
            if (end_chain) begin
               ptr_q[cur] <= ptr_q[cur] + AW'(1);
               fet_q[cur] <= 1'b1;
            end else begin
               act_q[cur] <= 1'b0;
            end
         end
         if (st_ok) begin
            act_q[start_sub] <= 1'b1;
            fet_q[start_sub] <= 1'b1;
            ptr_q[start_sub] <= start_ptr;
         end
      end
   end

   mpx_irq #(.N(NSUB)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vld (done_vld),
      .set_idx (cur),
      .ack     (irq_ack),
      .irq     (irq),
      .irq_sub (irq_sub)
   );

   // R9
   gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_gnt));
   // R10
   gnt_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|dev_gnt) |-> (|(dev_gnt & dev_req & act_q)));
   // R3
   start_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_valid |=> (start_accept != start_busy));
   // R4
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (cnt_q[cur] != '0));
   // R2
   fetch_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CMD) |=> (state == ST_CMDW));
endmodule

// File: tb/mpx_channel_bench.sv
`timescale 1ns/1ps
module mpx_channel_bench;
   localparam int NSUB = 8;
   localparam int SW   = 3;

   // row: [31:24] subchannel, [23:16] operation, [15:8] first count, [7:0] chained count
   localparam logic [31:0] ROWS [6] = '{
      32'h03_00_04_00,   // R4 output
      32'h05_01_03_00,   // R5 input
      32'h00_80_02_03,   // R6 output chain
      32'h07_81_01_04,   // R6 input chain
      32'h02_00_00_00,   // R7 zero count
      32'h06_80_00_02    // R7 zero count then chain
   };

   logic clk = 0, rst_n = 0;
   logic start_valid = 0, irq_ack = 0;
   logic [SW-1:0] start_sub = '0;
   logic [15:0] start_ptr = '0;
   logic start_accept, start_busy, mem_req, mem_we, irq;
   logic [15:0] mem_addr;
   logic [7:0] mem_wdata, dev_wdata;
   logic [31:0] mem_rdata;
   logic [NSUB-1:0] dev_req, dev_gnt;
   logic [8*NSUB-1:0] dev_rdata;
   logic [SW-1:0] irq_sub;

   logic [31:0] mem [256];
   int allow [NSUB];
   int gx [NSUB];
   logic [7:0] olog [NSUB][64];
   int gseq [64];
   int gcnt, cyc;
   logic clr = 0;
   int checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   mpx_channel u_mpx_channel (.*);

   function automatic logic [7:0] pat(int s, int k);
      return 8'(s * 37 + k * 11 + 3);
   endfunction

   always_comb
      for (int i = 0; i < NSUB; i++) begin
         dev_req[i] = gx[i] < allow[i];
         dev_rdata[i*8 +: 8] = pat(i, gx[i]);
      end

   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) mem[mem_addr[7:0]] <= {24'h0, mem_wdata};
         mem_rdata <= mem[mem_addr[7:0]];
      end
      if (clr) begin
         for (int i = 0; i < NSUB; i++) gx[i] <= 0;
         gcnt <= 0;
      end else begin
         for (int i = 0; i < NSUB; i++)
            if (dev_gnt[i]) begin
               olog[i][gx[i] % 64] <= dev_wdata;
               gx[i] <= gx[i] + 1;
               gseq[gcnt % 64] <= i;
               gcnt <= gcnt + 1;
            end
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         errors = errors + 1;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic reset_io();
      clr = 1;
      @(negedge clk);
      clr = 0;
      for (int i = 0; i < NSUB; i++) allow[i] = 0;
      for (int a = 0; a < 256; a++) mem[a] = {24'h0, 8'(a * 5 + 9)};
   endtask

   task automatic start(input int s, input int p);
      start_valid = 1; start_sub = SW'(s); start_ptr = 16'(p);
      @(negedge clk);
      start_valid = 0;
   endtask

   task automatic wait_irq();
      for (int t = 0; t < 2000 && !irq; t++) @(negedge clk);
   endtask

   task automatic ack();
      irq_ack = 1;
      @(negedge clk);
      irq_ack = 0;
      @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < NSUB; i++) begin allow[i] = 0; gx[i] = 0; end
      gcnt = 0; cyc = 0; mem_rdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(!irq && !mem_req && dev_gnt == 0 && !start_accept && !start_busy,
          "R1 reset outputs", {irq, mem_req, start_accept, start_busy}, 0);

      for (int r = 0; r < 6; r++) begin
         int s, c1, c2, tot, p, bad, fa, fe;
         logic [7:0] op;
         string tag;
         s = ROWS[r][31:24]; op = ROWS[r][23:16];
         c1 = ROWS[r][15:8]; c2 = op[7] ? int'(ROWS[r][7:0]) : 0;
         tot = c1 + c2; p = 16 + 2 * r;
         tag = (c1 == 0) ? "R7" : op[7] ? "R6" : op[0] ? "R5" : "R4";
         reset_io();
         mem[p] = {op, 16'd128, 8'(c1)};
         mem[p + 1] = {7'h0, op[0], 16'd160, 8'(c2)};
         allow[s] = tot + 2;
         start(s, p);
         chk(start_accept && !start_busy, "R2 start accepted", start_accept, 1);
         wait_irq();
         chk(irq && irq_sub == SW'(s), {tag, " R8 completion sub"}, irq_sub, s);
         chk(gx[s] == tot, {tag, " byte count"}, gx[s], tot);
         bad = 0; fa = 0; fe = 0;
         for (int k = 0; k < tot; k++) begin
            int a;
            logic [7:0] got, exp;
            a = (k < c1) ? 128 + k : 160 + k - c1;
            got = op[0] ? mem[a][7:0] : olog[s][k];
            exp = op[0] ? pat(s, k) : 8'(a * 5 + 9);
            if (got != exp && bad == 0) begin fa = got; fe = exp; end
            if (got != exp) bad++;
         end
         chk(bad == 0, {tag, " byte values"}, fa, fe);
         ack();
         chk(!irq, "R8 ack clears irq", irq, 0);
      end

      // R3 and R10: restart of running subchannel, idle subchannel requesting
      reset_io();
      mem[40] = {8'h00, 16'd128, 8'd8};
      mem[41] = {8'h01, 16'd200, 8'd2};
      allow[4] = 5;
      start(1, 40);
      chk(start_accept, "R2 accept sub1", start_accept, 1);
      repeat (10) @(negedge clk);
      start(1, 41);
      chk(start_busy && !start_accept, "R3 busy on active restart", start_busy, 1);
      allow[1] = 8;
      wait_irq();
      chk(irq && irq_sub == 1, "R3 original program completes", irq_sub, 1);
      chk(gx[1] == 8 && olog[1][7] == 8'(135 * 5 + 9), "R3 program unchanged", gx[1], 8);
      chk(gx[4] == 0, "R10 idle request not granted", gx[4], 0);
      ack();

      // R9 and R8: two requesters together
      reset_io();
      mem[50] = {8'h00, 16'd128, 8'd4};
      mem[52] = {8'h00, 16'd160, 8'd4};
      start(1, 50);
      start(2, 52);
      repeat (10) @(negedge clk);
      allow[1] = 4; allow[2] = 4;
      for (int t = 0; t < 500 && gcnt < 8; t++) @(negedge clk);
      repeat (4) @(negedge clk);
      begin
         int alt;
         alt = (gseq[0] == 1) ? 1 : 0;
         for (int k = 0; k < 7; k++) if (gseq[k] == gseq[k + 1]) alt = 0;
         chk(gcnt == 8 && alt == 1, "R9 round-robin alternation", gseq[0], 1);
      end
      chk(irq && irq_sub == 1, "R8 lowest pending first", irq_sub, 1);
      ack();
      chk(irq && irq_sub == 2, "R8 second pending reported", irq_sub, 2);
      ack();
      chk(!irq, "R8 all completions cleared", irq, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule